// File: doc/BRIEF.md
# Programmable Vertical Transfer Pulse Generator

This block drives the two transfer-gate outputs of a CCD timing generator. A rising edge on the vertical sync input begins a frame. Each rising edge on the horizontal sync input advances a line counter. At the start of one programmed line, a 13-bit pixel counter starts from zero. It advances once per clock and is never cleared by a later horizontal sync, so a pulse can run on past the line boundary.

Two start positions and one shared width describe two candidate pulses. Each output uses a 1-bit selector to pick one of them. The output is then gated by its own bit in a mask register and by a global enable.

Software writes go through a simple write port into shadow copies. The shadow copies are transferred to the working set on each vertical sync edge, so a frame always runs with one consistent configuration.

Top module: `vxfer_pulse_gen`

## Requirements
- R1: While reset is asserted, and after it until a frame is configured, both outputs are low.
- R2: With pixel count p, selected start s and width w, an output is high in the clock after the count was p, for every p with s <= p < s+w. This gives exactly w high cycles. A width of 0 gives no pulse.
- R3: Selector bit 0 (register 4) chooses the start position for output 1, and selector bit 1 chooses it for output 2. The value 0 picks start position 0 (register 0) and 1 picks start position 1 (register 1).
- R4: The pixel counter starts at line index L, where L is the 7-bit active-line value (register 3). Line 0 begins at the vertical sync edge, and each later line begins at a horizontal sync edge. So L=3 places the pulse in the fourth line, and L=0 starts counting at the vertical sync edge itself.
- R5: Once the pixel counter is started, horizontal sync edges do not clear it, so a pulse continues across a line boundary.
- R6: The pixel counter stops at 8191 and does not wrap. A window that extends past 8191 is cut short there, and no second pulse occurs in the same frame.
- R7: Mask register 5 has 6 bits. Bit 1 passes output 1 and bit 3 passes output 2. The code 0x00 blocks both outputs, 0x02 passes output 1 only, 0x08 passes output 2 only, and 0x0A passes both.
- R8: Enable register 6, bit 0, forces both outputs low when it is 0.
- R9: A write only changes the shadow copy. The new value takes effect at the next vertical sync edge, and a write in the middle of a frame leaves that frame's pulse unchanged.
- R10: A vertical sync edge stops any pixel count still running from the previous frame, so an unfinished pulse window never carries over into the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vd_i | input | 1 | Vertical sync; its rising edge starts a frame |
| hd_i | input | 1 | Horizontal sync; its rising edge starts a line |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 start0, 1 start1, 2 width, 3 active line, 4 selectors, 5 mask, 6 enable |
| wr_data_i | input | 13 | Register write data, aligned to bit 0 |
| xfer_o | output | 2 | Transfer pulses; bit 0 is output 1 and bit 1 is output 2 |

## Verification
The hardest state to reach is the pixel counter reaching its 8191 ceiling with a pulse window still open. This needs a frame that runs longer than 8191 clocks after the active line. The bench builds one from about two hundred short lines, with the start position a few counts below the ceiling, and keeps the frame running well past the ceiling to show the pulse is cut short and no second pulse appears.

The other two hard cases are a vertical sync that arrives while the counter is still running, and a window that crosses a horizontal sync. The bench reaches them by choosing frame lengths and start positions that put the window beyond the frame end or across a line edge.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;

  typedef enum logic [2:0] {
    ADDR_START0 = 3'd0,
    ADDR_START1 = 3'd1,
    ADDR_WIDTH  = 3'd2,
    ADDR_LINE   = 3'd3,
    ADDR_SEL    = 3'd4,
    ADDR_MASK   = 3'd5,
    ADDR_ENABLE = 3'd6
  } vx_addr_e;

  // mask bit that passes output k (sparse layout: 1, 3, ...)
  function automatic int mask_bit(input int k);
    return 2 * k + 1;
  endfunction

endpackage

// File: rtl/vxfer_regs.sv
module vxfer_regs
  import vxfer_pkg::*;
#(
  parameter int PIX_W  = 13,
  parameter int WID_W  = 8,
  parameter int LINE_W = 7,
  parameter int N_OUT  = 2,
  parameter int MASK_W = 6,
  parameter int DATA_W = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          load,
  output logic [1:0][PIX_W-1:0]         start_w,
  output logic [WID_W-1:0]              width_w,
  output logic [LINE_W-1:0]             line_w,
  output logic [LINE_W-1:0]             line_sh,
  output logic [N_OUT-1:0]              sel_w,
  output logic [MASK_W-1:0]             mask_w,
  output logic                          en_w
);

  logic [1:0][PIX_W-1:0] start_s;
  logic [WID_W-1:0]      width_s;
  logic [LINE_W-1:0]     line_s;
  logic [N_OUT-1:0]      sel_s;
  logic [MASK_W-1:0]     mask_s;
  logic                  en_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_s <= '0;
      width_s <= '0;
      line_s  <= '0;
      sel_s   <= '0;
      mask_s  <= '0;
      en_s    <= 1'b0;
    end else if (wr_en) begin
      case (vx_addr_e'(wr_addr))
        ADDR_START0: start_s[0] <= wr_data[PIX_W-1:0];
        ADDR_START1: start_s[1] <= wr_data[PIX_W-1:0];
        ADDR_WIDTH:  width_s    <= wr_data[WID_W-1:0];
        ADDR_LINE:   line_s     <= wr_data[LINE_W-1:0];
        ADDR_SEL:    sel_s      <= wr_data[N_OUT-1:0];
        ADDR_MASK:   mask_s     <= wr_data[MASK_W-1:0];
        ADDR_ENABLE: en_s       <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_w <= '0;
      width_w <= '0;
      line_w  <= '0;
      sel_w   <= '0;
      mask_w  <= '0;
      en_w    <= 1'b0;
    end else if (load) begin
      start_w <= start_s;
      width_w <= width_s;
      line_w  <= line_s;
      sel_w   <= sel_s;
      mask_w  <= mask_s;
      en_w    <= en_s;
    end
  end

  assign line_sh = line_s;

  AST_WORKING_ONLY_AT_VD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({start_w, width_w, line_w, sel_w, mask_w, en_w})); // R9

endmodule

// File: rtl/vxfer_timebase.sv
module vxfer_timebase #(
  parameter int PIX_W  = 13,
  parameter int LINE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vd,
  input  logic              hd,
  input  logic [LINE_W-1:0] line_w,
  input  logic [LINE_W-1:0] line_sh,
  output logic              vd_rise,
  output logic              hd_rise,
  output logic              start_evt,
  output logic              run,
  output logic [PIX_W-1:0]  pix
);

  localparam int          LCNT_W = LINE_W + 1;
  localparam logic [LCNT_W-1:0] LCNT_MAX = '1;
  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;

  logic              vd_q, hd_q;
  logic [LCNT_W-1:0] lcnt, lcnt_inc;
  logic              lcnt_sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd_q <= 1'b0;
      hd_q <= 1'b0;
    end else begin
      vd_q <= vd;
      hd_q <= hd;
    end
  end

  assign vd_rise  = vd & ~vd_q;
  assign hd_rise  = hd & ~hd_q;
  assign lcnt_sat = (lcnt == LCNT_MAX);
  assign lcnt_inc = lcnt_sat ? lcnt : lcnt + 1'b1;

  // line counter: cleared by VD, advanced by HD, saturates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lcnt <= LCNT_MAX;
    else if (vd_rise)  lcnt <= '0;
    else if (hd_rise)  lcnt <= lcnt_inc;
  end

  // the VD edge uses the configuration that is being loaded at that edge
  assign start_evt = vd_rise ? (line_sh == '0)
                             : (hd_rise && !lcnt_sat &&
                                (lcnt_inc == {1'b0, line_w}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      pix <= '0;
    end else if (start_evt) begin
      run <= 1'b1;
      pix <= '0;
    end else if (vd_rise) begin
      run <= 1'b0;
      pix <= '0;
    end else if (run) begin
      if (pix == PIX_MAX) run <= 1'b0;
      else                pix <= pix + 1'b1;
    end
  end

  AST_COUNTER_STOPS_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start_evt && !vd_rise && pix == PIX_MAX) |=> (!run && pix == PIX_MAX)); // R6
  AST_HD_DOES_NOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hd_rise && !start_evt && !vd_rise && pix != PIX_MAX) |=> (run && pix != '0)); // R5
  AST_VD_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_rise && !start_evt) |=> !run); // R10
  AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (run && pix == '0)); // R4

endmodule

// File: rtl/vxfer_out_stage.sv
module vxfer_out_stage
  import vxfer_pkg::*;
#(
  parameter int PIX_W  = 13,
  parameter int WID_W  = 8,
  parameter int N_OUT  = 2,
  parameter int MASK_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [PIX_W-1:0]      pix,
  input  logic [1:0][PIX_W-1:0] start_w,
  input  logic [WID_W-1:0]      width_w,
  input  logic [N_OUT-1:0]      sel_w,
  input  logic [MASK_W-1:0]     mask_w,
  input  logic                  en_w,
  output logic [N_OUT-1:0]      out_q
);

  localparam int SUM_W = PIX_W + 1;

  // start <= p < start + width, evaluated one bit wider so the end never wraps
  function automatic logic in_window(input logic [PIX_W-1:0] p,
                                     input logic [PIX_W-1:0] s,
                                     input logic [WID_W-1:0] w);
    logic [SUM_W-1:0] lo, hi, pp;
    lo = {1'b0, s};
    hi = lo + SUM_W'(w);
    pp = {1'b0, p};
    return (pp >= lo) && (pp < hi);
  endfunction

  logic [N_OUT-1:0] hit, pass;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int MB = mask_bit(k);
    logic [PIX_W-1:0] start_sel;

    assign start_sel = sel_w[k] ? start_w[1] : start_w[0];
    assign hit[k]    = run && in_window(pix, start_sel, width_w);
    assign pass[k]   = en_w && mask_w[MB];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q[k] <= 1'b0;
      else        out_q[k] <= hit[k] && pass[k];
    end

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_w[MB] |=> !out_q[k]); // R7
    AST_EN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_w |=> !out_q[k]); // R8
    AST_ZERO_WIDTH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (width_w == '0) |=> !out_q[k]); // R2
    AST_ONLY_WHILE_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
      out_q[k] |-> $past(run)); // R10
  end

endmodule

// File: rtl/vxfer_pulse_gen.sv
module vxfer_pulse_gen #(
  parameter int PIX_W  = 13,
  parameter int WID_W  = 8,
  parameter int LINE_W = 7,
  parameter int N_OUT  = 2,
  parameter int MASK_W = 6,
  parameter int DATA_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vd_i,
  input  logic              hd_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [N_OUT-1:0]  xfer_o
);

  logic [1:0][PIX_W-1:0] start_w;
  logic [WID_W-1:0]      width_w;
  logic [LINE_W-1:0]     line_w, line_sh;
  logic [N_OUT-1:0]      sel_w;
  logic [MASK_W-1:0]     mask_w;
  logic                  en_w;

  // named internal events, brought out for the assertions
  logic                  vd_rise, hd_rise, start_evt, run;
  logic [PIX_W-1:0]      pix;

  vxfer_regs #(
    .PIX_W(PIX_W), .WID_W(WID_W), .LINE_W(LINE_W),
    .N_OUT(N_OUT), .MASK_W(MASK_W), .DATA_W(DATA_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .load(vd_rise),
    .start_w(start_w), .width_w(width_w), .line_w(line_w), .line_sh(line_sh),
    .sel_w(sel_w), .mask_w(mask_w), .en_w(en_w)
  );

  vxfer_timebase #(.PIX_W(PIX_W), .LINE_W(LINE_W)) i_timebase (
    .clk(clk), .rst_n(rst_n), .vd(vd_i), .hd(hd_i),
    .line_w(line_w), .line_sh(line_sh),
    .vd_rise(vd_rise), .hd_rise(hd_rise), .start_evt(start_evt),
    .run(run), .pix(pix)
  );

  vxfer_out_stage #(
    .PIX_W(PIX_W), .WID_W(WID_W), .N_OUT(N_OUT), .MASK_W(MASK_W)
  ) i_out (
    .clk(clk), .rst_n(rst_n), .run(run), .pix(pix),
    .start_w(start_w), .width_w(width_w), .sel_w(sel_w),
    .mask_w(mask_w), .en_w(en_w), .out_q(xfer_o)
  );

  logic unused_bits;
  assign unused_bits = ^{wr_data_i, hd_rise};

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (xfer_o == '0)); // R1

endmodule

// File: tb/test_vxfer_pulse_gen.sv
`timescale 1ns/1ps
module test_vxfer_pulse_gen;

  localparam int LINE_LEN = 40;
  localparam int PMAX     = 8191;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vd = 1'b0, hd = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [12:0] wr_data = '0;
  logic [1:0]  xfer;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk; // 125 MHz

  vxfer_pulse_gen i_vxfer_pulse_gen (
    .clk(clk), .rst_n(rst_n), .vd_i(vd), .hd_i(hd),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .xfer_o(xfer)
  );

  // ---------------- behavioural reference model ----------------
  int sh_start[2], sh_w, sh_line, sh_sel[2], sh_mask, sh_en;
  int wk_start[2], wk_w, wk_line, wk_sel[2], wk_mask, wk_en;
  int m_line, m_pix;
  bit m_run, m_vd_p, m_hd_p;
  bit exp_out[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (sh_start[i]) begin
        sh_start[i] = 0; wk_start[i] = 0; sh_sel[i] = 0; wk_sel[i] = 0;
        exp_out[i] = 0;
      end
      sh_w = 0; wk_w = 0; sh_line = 0; wk_line = 0;
      sh_mask = 0; wk_mask = 0; sh_en = 0; wk_en = 0;
      m_line = 255; m_pix = 0; m_run = 0; m_vd_p = 0; m_hd_p = 0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        int s;
        s = wk_start[wk_sel[k]];
        exp_out[k] = m_run && wk_en != 0 && ((wk_mask >> (2*k+1)) & 1) != 0 &&
                     m_pix >= s && m_pix < s + wk_w;
      end
      if (vd && !m_vd_p) begin
        wk_start = sh_start; wk_w = sh_w; wk_line = sh_line;
        wk_sel = sh_sel; wk_mask = sh_mask; wk_en = sh_en;
        m_line = 0; m_pix = 0; m_run = (wk_line == 0);
      end else begin
        bit started;
        started = 0;
        if (hd && !m_hd_p && m_line < 255) begin
          m_line++;
          if (m_line == wk_line) started = 1;
        end
        if (started) begin
          m_pix = 0; m_run = 1;
        end else if (m_run) begin
          if (m_pix == PMAX) m_run = 0;
          else m_pix++;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: sh_start[0] = wr_data;
          3'd1: sh_start[1] = wr_data;
          3'd2: sh_w = wr_data & 8'hFF;
          3'd3: sh_line = wr_data & 7'h7F;
          3'd4: begin sh_sel[0] = wr_data[0]; sh_sel[1] = wr_data[1]; end
          3'd5: sh_mask = wr_data & 6'h3F;
          3'd6: sh_en = wr_data[0];
          default: ;
        endcase
      end
      m_vd_p = vd; m_hd_p = hd;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      checks++;
      if (xfer[k] !== exp_out[k]) begin
        errors++;
        $display("FAIL %s cycle %0d out%0d actual=%b expected=%b",
                 cur_req, cycles, k + 1, xfer[k], exp_out[k]);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d actual=running expected=done", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 13'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic config_all(input int s0, input int s1, input int w, input int ln,
                            input int sel, input int mask, input int en);
    wr(0, s0); wr(1, s1); wr(2, w); wr(3, ln); wr(4, sel); wr(5, mask); wr(6, en);
  endtask

  // one frame: VD edge, then nlines lines; optional write during line wl
  task automatic run_frame(input int nlines, input int wl, input int wa, input int wd,
                           output int c1, output int c2);
    c1 = 0; c2 = 0;
    for (int ln = 0; ln < nlines; ln++) begin
      for (int p = 0; p < LINE_LEN; p++) begin
        @(negedge clk);
        c1 += int'(xfer[0]); c2 += int'(xfer[1]);
        vd = (ln == 0 && p == 0);
        hd = (ln != 0 && p == 0);
        wr_en = (ln == wl && p == 1);
        wr_addr = 3'(wa); wr_data = 13'(wd);
      end
    end
    @(negedge clk);
    c1 += int'(xfer[0]); c2 += int'(xfer[1]);
    vd = 1'b0; hd = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    int c1, c2;
    int masks[4] = '{0, 2, 8, 10};

    // R1: reset state
    repeat (3) @(negedge clk);
    check_eq("R1", "outputs in reset", int'(xfer), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_eq("R1", "outputs after reset", int'(xfer), 0);

    // R2 / R4: basic pulse in line index 3
    cur_req = "R4";
    config_all(10, 10, 8, 3, 0, 10, 1);
    run_frame(6, -1, 0, 0, c1, c2);   // loads configuration at its VD edge
    check_eq("R2", "width count out1", c1, 8);
    check_eq("R2", "width count out2", c2, 8);

    // R3: each output picks its own start position
    cur_req = "R3";
    config_all(5, 20, 4, 2, 1, 10, 1);
    run_frame(6, -1, 0, 0, c1, c2);
    check_eq("R3", "out1 start1 count", c1, 4);
    check_eq("R3", "out2 start0 count", c2, 4);
    wr(4, 2);
    run_frame(6, -1, 0, 0, c1, c2);
    check_eq("R3", "swapped select out1", c1, 4);

    // R7: all four mask codes
    cur_req = "R7";
    foreach (masks[i]) begin
      config_all(12, 12, 6, 1, 0, masks[i], 1);
      run_frame(4, -1, 0, 0, c1, c2);
      check_eq("R7", $sformatf("mask 0x%02h out1", masks[i]), c1, (masks[i] & 2) ? 6 : 0);
      check_eq("R7", $sformatf("mask 0x%02h out2", masks[i]), c2, (masks[i] & 8) ? 6 : 0);
    end

    // R8: global enable off
    cur_req = "R8";
    config_all(12, 12, 6, 1, 0, 10, 0);
    run_frame(4, -1, 0, 0, c1, c2);
    check_eq("R8", "disabled out1", c1, 0);
    check_eq("R8", "disabled out2", c2, 0);

    // R2: zero width
    cur_req = "R2";
    config_all(12, 12, 0, 1, 0, 10, 1);
    run_frame(4, -1, 0, 0, c1, c2);
    check_eq("R2", "zero width", c1 + c2, 0);

    // R4: active line 0 counts from the VD edge itself
    cur_req = "R4";
    config_all(3, 3, 5, 0, 0, 10, 1);
    run_frame(3, -1, 0, 0, c1, c2);
    check_eq("R4", "line 0 pulse", c1, 5);

    // R5: window crosses the next HD
    cur_req = "R5";
    config_all(35, 35, 20, 1, 0, 10, 1);
    run_frame(5, -1, 0, 0, c1, c2);
    check_eq("R5", "pulse across HD", c1, 20);

    // R9: write in mid-frame has no effect until the next VD
    cur_req = "R9";
    config_all(10, 10, 6, 3, 0, 10, 1);
    run_frame(6, -1, 0, 0, c1, c2);
    run_frame(6, 1, 2, 15, c1, c2);
    check_eq("R9", "old width kept in frame", c1, 6);
    run_frame(6, -1, 0, 0, c1, c2);
    check_eq("R9", "new width after VD", c1, 15);

    // R10: VD cuts a counter that has not reached its window
    cur_req = "R10";
    config_all(60, 60, 10, 1, 0, 10, 1);
    run_frame(2, -1, 0, 0, c1, c2);
    run_frame(2, -1, 0, 0, c1, c2);
    check_eq("R10", "short frame no pulse", c1, 0);
    run_frame(4, -1, 0, 0, c1, c2);
    check_eq("R10", "full frame pulse", c1, 10);

    // R6: counter stops at 8191, window cut short, no second pulse
    cur_req = "R6";
    config_all(8188, 8188, 10, 3, 0, 10, 1);
    run_frame(2, -1, 0, 0, c1, c2);
    run_frame(215, -1, 0, 0, c1, c2);
    check_eq("R6", "truncated pulse out1", c1, PMAX + 1 - 8188);
    check_eq("R6", "truncated pulse out2", c2, PMAX + 1 - 8188);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule